// File: doc/BRIEF.md
# Dual-Channel Power Switch Sequencer

This block converts the active command word of each of two card-socket channels into per-switch control for a supply switch (VCC) and a programming-voltage switch (VPP) on each channel. Each of the four switches is driven to one of three states: grounded, floating (high impedance), or connected to a chosen supply. A one-cycle ramp-start strobe marks each entry into the connected state, so that the analog slew control can begin a controlled rise.

Digital flags from external comparators feed the block. These flags report overcurrent per switch, die over-temperature and cool-down, undervoltage on the 3.3 V-class and 5 V-class inputs, the arm and disarm levels of each channel's 12 V input, and logic-supply undervoltage. The block applies them with fixed priorities. An overcurrent causes an immediate off/retry and becomes a fault only after it persists. Thermal shutdown uses hysteresis between two thresholds. Supply lockout applies per switch. The block sends single-cycle fault pulses to a separate fault-latch block. All interfaces are plain level or pulse pins: nothing here streams data, so there is no valid/ready handshake and no back-pressure.

Top module: `pwrseq_dual`

## Requirements
- R1: After reset, every switch is grounded (`sw_mode` all 0), and `sw_src`, `ramp_go`, `sw_fault` and `cat_fault` are all 0. Switch index i uses bits [2i+1:2i] of `sw_mode`. Index 0 is VCC of channel A, 1 is VPP of channel A, 2 is VCC of channel B and 3 is VPP of channel B. The mode codes are 0 = ground, 1 = high impedance and 2 = connected.
- R2: The command word for a channel has these bits: [5] VCC on, [4] VCC source, [3] VCC float, [2] VPP on, [1] VPP source and [0] VPP float. With VCC float low, an on bit of 0 grounds VCC. An on bit of 1 connects it, with `sw_src` = 1 for the 3.3 V-class input and 0 for the 5 V-class input.
- R3: With VPP float low, a VPP on bit of 0 grounds VPP. An on bit of 1 connects it, with `sw_src` = 1 for the channel's 12 V input and 0 for that channel's VCC output.
- R4: A float bit puts its output into high impedance whatever its on bit says. `sw_src` is 0 whenever a switch is not connected.
- R5: If a connected switch sees its overcurrent flag, it opens at the next edge. It stays open for RETRY_CYC further edges, then reconnects and strobes the ramp.
- R6: An overcurrent raises one `sw_fault` pulse for that switch only after the flag has been high on CYC_PER_US*OC_PERSIST_US consecutive edges. A shorter burst raises none.
- R7: `ramp_go` for a switch is high for exactly the one cycle in which that switch enters the connected state.
- R8: Over-temperature, while any switch is commanded on, pulses `cat_fault` and opens all four switches, grounds included. They stay open until the cool flag is seen, and then they reconnect with ramp strobes.
- R9: When no switch is commanded on (each is grounded or floating), the over-temperature flag is ignored.
- R10: If the supply selected for a commanded VCC is under lockout, that switch floats. One `sw_fault` pulse and one `cat_fault` pulse occur, and the other switches are unaffected.
- R11: A VPP sourced from 12 V floats until that channel's arm flag has been seen. It stays usable with both flags low, and floats again after the disarm flag. Only a new arm flag restores it.
- R12: Logic-supply undervoltage floats all four outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_a | input | 6 | Active command, channel A |
| cmd_b | input | 6 | Active command, channel B |
| oc_det | input | 4 | Overcurrent flag per switch (switch index order) |
| hot_det | input | 1 | Die above upper temperature threshold |
| cool_det | input | 1 | Die below lower temperature threshold |
| uv_3v3 | input | 1 | 3.3 V-class input below lockout |
| uv_5v | input | 1 | 5 V-class input below lockout |
| hv_above_arm | input | 2 | 12 V input above arm level ([0] = A, [1] = B) |
| hv_below_disarm | input | 2 | 12 V input below disarm level ([0] = A, [1] = B) |
| logic_uv | input | 1 | Logic-supply undervoltage |
| sw_mode | output | 8 | 2-bit state per switch |
| sw_src | output | 4 | Source select per connected switch |
| ramp_go | output | 4 | One-cycle ramp-start strobe per switch |
| sw_fault | output | 4 | Fault pulse per switch |
| cat_fault | output | 1 | Catastrophic fault pulse (thermal or lockout) |

## Verification
The command decode, the float override, supply lockout, logic undervoltage and the overcurrent opening all appear at the first clock edge after the input changes. The shutdown latch and the 12 V arm latch each add one register stage, so those effects appear at the second edge. In that case `cat_fault` pulses at the first edge and the modes change at the second. Ramp strobes and lockout faults come out in the same cycle as the mode change they belong to. An overcurrent fault comes out on the edge of the N-th consecutive high sample. The bench drives every input just after a falling edge and reads outputs at later falling edges, counting the exact number of rising edges to each expected change. Where absence is required, it counts pulses over a whole window.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
  typedef enum logic [1:0] {
    SW_GND = 2'd0,
    SW_HIZ = 2'd1,
    SW_ON  = 2'd2
  } sw_mode_e;

  localparam int NUM_CH = 2;
  localparam int SW_PER_CH = 2;
  localparam int NUM_SW = NUM_CH * SW_PER_CH;
  localparam int CMD_W = 6;
endpackage

// File: rtl/pwrseq_thermal.sv
module pwrseq_thermal (
  input  logic clk,
  input  logic rst_n,
  input  logic hot,
  input  logic cool,
  input  logic standby,
  output logic shut_o,
  output logic trip_o
);
  logic shut_q, trip_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shut_q <= 1'b0;
      trip_q <= 1'b0;
    end else begin
      if (shut_q) shut_q <= ~cool;
      else        shut_q <= hot & ~standby;
      trip_q <= ~shut_q & hot & ~standby;
    end
  end

  assign shut_o = shut_q;
  assign trip_o = trip_q;

  // R8: shutdown releases only after cool flag
  assert_cool_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shut_q) |-> $past(cool));
  // R9: standby ignores over-temperature
  assert_standby_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!shut_q && standby) |=> !shut_q);
endmodule

// File: rtl/pwrseq_arm.sv
module pwrseq_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic above,
  input  logic below,
  output logic armed_o
);
  logic armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       armed_q <= 1'b0;
    else if (armed_q) armed_q <= ~below;
    else              armed_q <= above & ~below;
  end

  assign armed_o = armed_q;

  assert_arm_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> $past(above));
  assert_arm_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(armed_q) |-> $past(below));
endmodule

// File: rtl/pwrseq_switch.sv
module pwrseq_switch
  import pwrseq_pkg::*;
#(
  parameter int RETRY_CYC   = 64,
  parameter int PERSIST_CYC = 500
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     want_on,
  input  logic     want_hiz,
  input  logic     lock,
  input  logic     force_off,
  input  logic     src_sel,
  input  logic     oc,
  output sw_mode_e mode_o,
  output logic     src_o,
  output logic     ramp_o,
  output logic     oc_flt_o,
  output logic     uv_flt_o
);
  localparam int RW = $clog2(RETRY_CYC + 1);
  localparam int PW = $clog2(PERSIST_CYC + 1);

  sw_mode_e mode_q, mode_d;
  logic [RW-1:0] retry_q;
  logic [PW-1:0] pers_q;
  logic src_q, ramp_q, oc_flt_q, uv_flt_q, blk_q, blocked, tripping;

  assign blocked  = want_on & ~want_hiz & ~force_off & lock;
  assign tripping = (mode_q == SW_ON) & oc;

  always_comb begin
    if (force_off || want_hiz)                mode_d = SW_HIZ;
    else if (!want_on)                        mode_d = SW_GND;
    else if (lock)                            mode_d = SW_HIZ;
    else if ((retry_q != '0) || tripping)     mode_d = SW_HIZ;
    else                                      mode_d = SW_ON;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= SW_GND;
      src_q    <= 1'b0;
      ramp_q   <= 1'b0;
      retry_q  <= '0;
      pers_q   <= '0;
      oc_flt_q <= 1'b0;
      blk_q    <= 1'b0;
      uv_flt_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      src_q  <= (mode_d == SW_ON) & src_sel;
      ramp_q <= (mode_d == SW_ON) & (mode_q != SW_ON);
      if (tripping)             retry_q <= RW'(RETRY_CYC);
      else if (retry_q != '0)   retry_q <= retry_q - 1'b1;
      if (!oc)                            pers_q <= '0;
      else if (pers_q != PW'(PERSIST_CYC)) pers_q <= pers_q + 1'b1;
      oc_flt_q <= oc & (pers_q == PW'(PERSIST_CYC - 1));
      blk_q    <= blocked;
      uv_flt_q <= blocked & ~blk_q;
    end
  end

  assign mode_o   = mode_q;
  assign src_o    = src_q;
  assign ramp_o   = ramp_q;
  assign oc_flt_o = oc_flt_q;
  assign uv_flt_o = uv_flt_q;

  assert_hiz_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    want_hiz |=> mode_q == SW_HIZ);
  assert_src_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != SW_ON) |-> !src_q);
  assert_oc_opens_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == SW_ON) && oc) |=> mode_q != SW_ON);
  assert_fault_after_oc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    oc_flt_q |-> $past(oc));
  assert_ramp_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_q |-> (mode_q == SW_ON && $past(mode_q) != SW_ON));
  assert_lock_floats_R10: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |=> mode_q == SW_HIZ);
endmodule

// File: rtl/pwrseq_dual.sv
module pwrseq_dual
  import pwrseq_pkg::*;
#(
  parameter int CYC_PER_US    = 250,
  parameter int OC_PERSIST_US = 2,
  parameter int RETRY_CYC     = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [5:0]  cmd_a,
  input  logic [5:0]  cmd_b,
  input  logic [3:0]  oc_det,
  input  logic        hot_det,
  input  logic        cool_det,
  input  logic        uv_3v3,
  input  logic        uv_5v,
  input  logic [1:0]  hv_above_arm,
  input  logic [1:0]  hv_below_disarm,
  input  logic        logic_uv,
  output logic [7:0]  sw_mode,
  output logic [3:0]  sw_src,
  output logic [3:0]  ramp_go,
  output logic [3:0]  sw_fault,
  output logic        cat_fault
);
  localparam int PERSIST_CYC = CYC_PER_US * OC_PERSIST_US;

  logic [CMD_W-1:0] cmd_c [NUM_CH];
  logic [NUM_CH-1:0] armed;
  logic [NUM_SW-1:0] want_on, want_hiz, lock, src_sel, src_w, ramp_w, oc_flt, uv_flt;
  sw_mode_e mode_w [NUM_SW];
  logic shut, therm_trip, standby, force_off;

  assign cmd_c[0] = cmd_a;
  assign cmd_c[1] = cmd_b;

  genvar c, s;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_ch
      pwrseq_arm u_arm (
        .clk(clk), .rst_n(rst_n),
        .above(hv_above_arm[c]), .below(hv_below_disarm[c]),
        .armed_o(armed[c])
      );
      // VCC switch of channel c
      assign want_on[2*c]    = cmd_c[c][5];
      assign src_sel[2*c]    = cmd_c[c][4];
      assign want_hiz[2*c]   = cmd_c[c][3];
      assign lock[2*c]       = cmd_c[c][4] ? uv_3v3 : uv_5v;
      // VPP switch of channel c
      assign want_on[2*c+1]  = cmd_c[c][2];
      assign src_sel[2*c+1]  = cmd_c[c][1];
      assign want_hiz[2*c+1] = cmd_c[c][0];
      assign lock[2*c+1]     = cmd_c[c][1] & ~armed[c];
    end

    for (s = 0; s < NUM_SW; s++) begin : g_sw
      pwrseq_switch #(.RETRY_CYC(RETRY_CYC), .PERSIST_CYC(PERSIST_CYC)) u_sw (
        .clk(clk), .rst_n(rst_n),
        .want_on(want_on[s]), .want_hiz(want_hiz[s]), .lock(lock[s]),
        .force_off(force_off), .src_sel(src_sel[s]), .oc(oc_det[s]),
        .mode_o(mode_w[s]), .src_o(src_w[s]), .ramp_o(ramp_w[s]),
        .oc_flt_o(oc_flt[s]), .uv_flt_o(uv_flt[s])
      );
      assign sw_mode[2*s +: 2] = mode_w[s];
    end
  endgenerate

  assign standby   = ~|(want_on & ~want_hiz);
  assign force_off = shut | logic_uv;

  pwrseq_thermal u_therm (
    .clk(clk), .rst_n(rst_n),
    .hot(hot_det), .cool(cool_det), .standby(standby),
    .shut_o(shut), .trip_o(therm_trip)
  );

  assign sw_src    = src_w;
  assign ramp_go   = ramp_w;
  assign sw_fault  = oc_flt | uv_flt;
  assign cat_fault = therm_trip | (|uv_flt);

  assert_shut_opens_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
    shut |=> sw_mode == 8'h55);
  assert_logic_uv_floats_R12: assert property (@(posedge clk) disable iff (!rst_n)
    logic_uv |=> sw_mode == 8'h55);
endmodule

// File: tb/sim_pwrseq_dual.sv
module sim_pwrseq_dual;
  localparam int RETRY = 3;
  localparam int PERS  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] cmd_a = '0, cmd_b = '0;
  logic [3:0] oc_det = '0;
  logic hot_det = 0, cool_det = 0, uv_3v3 = 0, uv_5v = 0, logic_uv = 0;
  logic [1:0] hv_above_arm = '0, hv_below_disarm = '0;
  logic [7:0] sw_mode;
  logic [3:0] sw_src, ramp_go, sw_fault;
  logic cat_fault;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwrseq_dual #(.CYC_PER_US(4), .OC_PERSIST_US(2), .RETRY_CYC(RETRY)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_a(cmd_a), .cmd_b(cmd_b), .oc_det(oc_det),
    .hot_det(hot_det), .cool_det(cool_det), .uv_3v3(uv_3v3), .uv_5v(uv_5v),
    .hv_above_arm(hv_above_arm), .hv_below_disarm(hv_below_disarm),
    .logic_uv(logic_uv), .sw_mode(sw_mode), .sw_src(sw_src),
    .ramp_go(ramp_go), .sw_fault(sw_fault), .cat_fault(cat_fault)
  );

  // {cmd_a, cmd_b, expected sw_mode, expected sw_src}
  localparam logic [23:0] VEC [10] = '{
    {6'b100000, 6'b000000, 8'h02, 4'b0000},
    {6'b110000, 6'b000000, 8'h02, 4'b0001},
    {6'b111000, 6'b000000, 8'h01, 4'b0000},
    {6'b110110, 6'b000000, 8'h0A, 4'b0011},
    {6'b000100, 6'b000000, 8'h08, 4'b0000},
    {6'b000101, 6'b000000, 8'h04, 4'b0000},
    {6'b000000, 6'b100000, 8'h20, 4'b0000},
    {6'b000000, 6'b110111, 8'h60, 4'b0100},
    {6'b000000, 6'b100110, 8'hA0, 4'b1000},
    {6'b101000, 6'b001001, 8'h51, 4'b0000}
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h, expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    cmd_a = '0; cmd_b = '0; oc_det = '0; hot_det = 0; cool_det = 0;
    uv_3v3 = 0; uv_5v = 0; logic_uv = 0; hv_above_arm = '0; hv_below_disarm = '0;
    rst_n = 0;
    step(2);
    rst_n = 1;
    step(1);
  endtask

  task automatic arm_both();
    hv_above_arm = 2'b11;
    step(1);
    hv_above_arm = 2'b00;
    step(1);
  endtask

  initial begin
    int cnt;
    do_reset();
    // R1 reset state
    chk("R1 mode", sw_mode, 8'h00);
    chk("R1 src", {4'h0, sw_src}, 8'h00);
    chk("R1 ramp", {4'h0, ramp_go}, 8'h00);
    chk("R1 fault", {3'h0, sw_fault, cat_fault}, 8'h00);

    // R2/R3/R4 decode table
    arm_both();
    for (int i = 0; i < 10; i++) begin
      cmd_a = VEC[i][23:18];
      cmd_b = VEC[i][17:12];
      step(2);
      chk($sformatf("R2/R3/R4 vec%0d mode", i), sw_mode, VEC[i][11:4]);
      chk($sformatf("R2/R3/R4 vec%0d src", i), {4'h0, sw_src}, {4'h0, VEC[i][3:0]});
    end

    // R7 ramp strobe on entry
    do_reset();
    cmd_a = 6'b100000;
    step(1);
    chk("R7 strobe", {4'h0, ramp_go}, 8'h01);
    step(1);
    chk("R7 strobe once", {4'h0, ramp_go}, 8'h00);
    chk("R7 held on", sw_mode, 8'h02);

    // R5 overcurrent retry
    oc_det = 4'b0001;
    step(1);
    oc_det = '0;
    chk("R5 opens", sw_mode, 8'h01);
    step(RETRY);
    chk("R5 still open", sw_mode, 8'h01);
    step(1);
    chk("R5 reconnect", sw_mode, 8'h02);
    chk("R5 restrobe", {4'h0, ramp_go}, 8'h01);

    // R6 persistence: short burst no fault, long burst one pulse
    cnt = 0;
    oc_det = 4'b0001;
    for (int i = 0; i < PERS - 1; i++) begin step(1); if (sw_fault != 0) cnt++; end
    oc_det = '0;
    for (int i = 0; i < RETRY + 4; i++) begin step(1); if (sw_fault != 0) cnt++; end
    chk("R6 short burst", cnt[7:0], 8'd0);
    cnt = 0;
    oc_det = 4'b0001;
    for (int i = 0; i < PERS + 6; i++) begin step(1); if (sw_fault == 4'b0001) cnt++; end
    oc_det = '0;
    step(RETRY + 4);
    chk("R6 long burst one pulse", cnt[7:0], 8'd1);

    // R8 thermal shutdown with hysteresis
    do_reset();
    cmd_a = 6'b100000;
    step(2);
    hot_det = 1;
    step(1);
    hot_det = 0;
    chk("R8 cat pulse", {7'h0, cat_fault}, 8'h01);
    step(1);
    chk("R8 all open", sw_mode, 8'h55);
    step(4);
    chk("R8 held open", sw_mode, 8'h55);
    cool_det = 1;
    step(1);
    cool_det = 0;
    chk("R8 latch delay", sw_mode, 8'h55);
    step(1);
    chk("R8 resume", sw_mode, 8'h02);
    chk("R8 resume strobe", {4'h0, ramp_go}, 8'h01);

    // R9 standby ignores heat
    cmd_a = 6'b001001;
    step(2);
    cnt = 0;
    hot_det = 1;
    for (int i = 0; i < 3; i++) begin step(1); if (cat_fault) cnt++; end
    hot_det = 0;
    chk("R9 no cat", cnt[7:0], 8'd0);
    cmd_a = 6'b100000;
    step(2);
    chk("R9 not latched", sw_mode, 8'h02);

    // R10 supply lockout
    do_reset();
    cmd_a = 6'b100000;
    cmd_b = 6'b110000;
    step(2);
    uv_5v = 1;
    step(1);
    chk("R10 floats", sw_mode, 8'h21);
    chk("R10 sw fault", {4'h0, sw_fault}, 8'h01);
    chk("R10 cat fault", {7'h0, cat_fault}, 8'h01);
    chk("R10 other src", {4'h0, sw_src}, 8'h04);
    step(1);
    chk("R10 pulse once", {3'h0, sw_fault, cat_fault}, 8'h00);
    uv_5v = 0;
    step(1);
    chk("R10 recovers", sw_mode, 8'h22);

    // R11 12V arm hysteresis
    do_reset();
    cmd_a = 6'b000110;
    step(3);
    chk("R11 unarmed floats", sw_mode, 8'h04);
    hv_above_arm = 2'b01;
    step(1);
    hv_above_arm = 2'b00;
    chk("R11 arm delay", sw_mode, 8'h04);
    step(1);
    chk("R11 armed on", sw_mode, 8'h08);
    chk("R11 strobe", {4'h0, ramp_go}, 8'h02);
    step(3);
    chk("R11 holds between", sw_mode, 8'h08);
    hv_below_disarm = 2'b01;
    step(1);
    hv_below_disarm = 2'b00;
    step(1);
    chk("R11 disarmed", sw_mode, 8'h04);
    step(3);
    chk("R11 no rearm", sw_mode, 8'h04);

    // R12 logic undervoltage
    arm_both();
    cmd_a = 6'b110110;
    cmd_b = 6'b100000;
    step(2);
    logic_uv = 1;
    step(1);
    chk("R12 all float", sw_mode, 8'h55);
    logic_uv = 0;
    step(1);
    chk("R12 release", sw_mode, 8'h2A);

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule